// File: doc/BRIEF.md
# Soft-Mute Ramp Controller

This block sits in front of the gain multiplier of a multi-rate audio DAC. It turns an active-low mute request into a linear gain ramp. While the request is low, the gain falls to zero. While it is high, the gain rises back to full scale. The gain takes one step for each frame-clock strobe. The number of strobes in a complete ramp depends on the sample-rate speed mode, so the fade lasts the same real time at every rate. The block does not touch the output bias level. It only sets the amplitude, and a gain of zero means silence at the bias point.

The block also drives an active-low control line for an external analog mute circuit. This line goes low only once a down-ramp has reached zero. It rises again in the cycle after the request is lifted, long before the up-ramp ends. Reset, power-down and a clock-ratio fault also pull the line low. The fault inputs also act as a mute request, so the gain ramps down while either fault is held.

The gain is a level from 0 to FULL, where FULL = 4 × `BASE_FRAMES` (4608 by default). The step size is set when a ramp starts from rest, meaning at 0 or at FULL. It is kept until the block comes to rest again, and a change of direction part-way through a ramp does not restart it.

Top module: `smr_softmute`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `gain` is 0 and `mute_ctl_n` is 0.
- R2: With the ramp target up, each frame strobe raises `gain` by the step of the latched mode. `speed` code 00 is single speed (step 4, 1152 strobes from 0 to FULL). Code 01 is double speed (step 2, 2304 strobes). Code 10 and code 11 are quad speed (step 1, 4608 strobes).
- R3: With `mute_req_n` = 0, each strobe lowers `gain` by the latched step, reaching 0 after the same mode-dependent number of strobes.
- R4: `gain` changes only in the cycle after an input cycle with `frame_tick` = 1.
- R5: During a down-ramp, `mute_ctl_n` stays 1 while `gain` is non-zero. It becomes 0 in the same cycle that `gain` becomes 0.
- R6: When `mute_req_n` = 1 and neither fault is present, `mute_ctl_n` is 1 in the next cycle, whatever the value of `gain`.
- R7: A change of `mute_req_n` during a ramp reverses the direction from the present `gain`, without a jump.
- R8: A change of `speed` while `gain` is strictly between 0 and FULL does not alter the step until the ramp comes to rest.
- R9: `pwr_down` = 1 or `ratio_err` = 1 makes `mute_ctl_n` 0 in the next cycle. It also makes the ramp target down, so `gain` never rises while either fault is held.
- R10: `gain` stays within 0 to FULL at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mute_req_n | input | 1 | Mute request: 0 mutes, 1 normal |
| speed | input | 2 | Speed mode: 00 single, 01 double, 10/11 quad |
| frame_tick | input | 1 | One-cycle strobe per frame-clock period |
| pwr_down | input | 1 | Power-down status, active high |
| ratio_err | input | 1 | Master-to-frame clock ratio fault, active high |
| gain | output | $clog2(4*BASE_FRAMES+1) | Linear gain level, 0 to FULL |
| mute_ctl_n | output | 1 | External mute control, active low |

## Verification
The assertions assume that `frame_tick` is a single-cycle strobe that has already been synchronised to `clk`. They also assume that every input is stable across the clock edge. The bench keeps to these assumptions by changing inputs only on the falling edge. It pulses `frame_tick` for whole cycles and raises faults only through the same negedge driver. The bench changes the speed mode both at rest and part-way through a ramp, and it reverses the request mid-ramp. Because the gain then stays on multiples of the latched step, the step assertions see only legal arithmetic.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the soft-mute ramp controller.
// Assumes speed codes come straight from a mode register; code 11 is
// treated as quad speed.
package smr_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE   = 2'b00,
        SPD_DOUBLE   = 2'b01,
        SPD_QUAD     = 2'b10,
        SPD_QUAD_ALT = 2'b11
    } speed_e;

    localparam int STEP_W = 3;

    // Gain increment per frame strobe: full scale is 4x the single-speed count.
    function automatic logic [STEP_W-1:0] step_for(input speed_e s);
        case (s)
            SPD_SINGLE: return 3'd4;
            SPD_DOUBLE: return 3'd2;
            default:    return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/smr_step_sel.sv
`timescale 1ns/1ps
// Step selector: picks the per-strobe gain increment. A new speed mode is
// taken only while the ramp is at rest (gain 0 or full scale); during a ramp
// the latched step is held. Assumes at_rest comes from the level register.
module smr_step_sel
    import smr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        speed,
    input  logic              at_rest,
    output logic [STEP_W-1:0] step
);

    logic [STEP_W-1:0] step_q;

    // Choose the live mode at rest, otherwise keep the latched step.
    always_comb begin
        if (at_rest) step = step_for(speed_e'(speed));
        else         step = step_q;
    end

    // Latch the step in use so a ramp keeps it to the end.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= step_for(SPD_SINGLE);
        else        step_q <= step;
    end

    a_r8_step_held: assert property (@(posedge clk) disable iff (!rst_n)
        !at_rest |=> $stable(step_q));
    a_r2_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step) == 1);

endmodule

// File: rtl/smr_level_ramp.sv
`timescale 1ns/1ps
// Gain level register: moves by one step per frame strobe towards full scale
// when ramp_up is set, towards zero otherwise, and saturates at both ends.
// Assumes frame_tick is a one-cycle strobe synchronous to clk.
module smr_level_ramp
    import smr_pkg::*;
#(
    parameter int FULL  = 4608,
    parameter int LVL_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              ramp_up,
    input  logic [STEP_W-1:0] step,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  level_next,
    output logic              at_rest
);

    localparam logic [LVL_W-1:0] FULL_L = LVL_W'(FULL);

    logic [LVL_W-1:0] step_l;
    logic [LVL_W:0]   sum_up;

    assign step_l = LVL_W'(step);
    assign sum_up = {1'b0, level} + {1'b0, step_l};
    assign at_rest = (level == '0) || (level == FULL_L);

    // Next level: one saturating step per strobe in the target direction.
    always_comb begin
        level_next = level;
        if (frame_tick) begin
            if (ramp_up) begin
                if (sum_up >= {1'b0, FULL_L}) level_next = FULL_L;
                else                          level_next = sum_up[LVL_W-1:0];
            end else begin
                if (level <= step_l) level_next = '0;
                else                 level_next = level - step_l;
            end
        end
    end

    // Level register, cleared to silence by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level_next;
    end

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(level));
    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_L);
    a_r2_rise_by_step: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && ramp_up && level != FULL_L) |=>
        ({1'b0, level} == {1'b0, $past(level)} + {1'b0, $past(step_l)}));
    a_r3_fall_by_step: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !ramp_up && level != '0) |=>
        ({1'b0, level} + {1'b0, $past(step_l)} == {1'b0, $past(level)}));

endmodule

// File: rtl/smr_mute_out.sv
`timescale 1ns/1ps
// External mute line driver: low on fault, and low once a down-ramp has
// reached zero; high as soon as the target is up. Registered output.
// Assumes level_next is the value the level register takes at this edge.
module smr_mute_out #(
    parameter int LVL_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault,
    input  logic             ramp_up,
    input  logic [LVL_W-1:0] level_next,
    output logic             mute_ctl_n
);

    // Release on an up target or while signal is still present, unless faulted.
    always_ff @(posedge clk) begin
        if (!rst_n) mute_ctl_n <= 1'b0;
        else        mute_ctl_n <= !fault && (ramp_up || (level_next != '0));
    end

    a_r9_fault_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !mute_ctl_n);
    a_r6_fast_release: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_up |=> mute_ctl_n);

endmodule

// File: rtl/smr_softmute.sv
`timescale 1ns/1ps
// Soft-mute ramp controller top. Combines mute request and fault inputs into
// a ramp target, then drives the gain level and the external mute line.
// Assumes all inputs are synchronous to clk and frame_tick is a single-cycle strobe.
module smr_softmute
    import smr_pkg::*;
#(
    parameter int BASE_FRAMES = 1152,
    localparam int FULL       = 4 * BASE_FRAMES,
    localparam int LVL_W      = $clog2(FULL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mute_req_n,
    input  logic [1:0]       speed,
    input  logic             frame_tick,
    input  logic             pwr_down,
    input  logic             ratio_err,
    output logic [LVL_W-1:0] gain,
    output logic             mute_ctl_n
);

    logic              fault;
    logic              ramp_up;
    logic              at_rest;
    logic [STEP_W-1:0] step;
    logic [LVL_W-1:0]  level_next;

    // Ramp target: up only on a normal request with no fault present.
    always_comb begin
        fault   = pwr_down || ratio_err;
        ramp_up = mute_req_n && !fault;
    end

    smr_step_sel u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .speed   (speed),
        .at_rest (at_rest),
        .step    (step)
    );

    smr_level_ramp #(.FULL(FULL), .LVL_W(LVL_W)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .ramp_up    (ramp_up),
        .step       (step),
        .level      (gain),
        .level_next (level_next),
        .at_rest    (at_rest)
    );

    smr_mute_out #(.LVL_W(LVL_W)) u_mute (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (fault),
        .ramp_up    (ramp_up),
        .level_next (level_next),
        .mute_ctl_n (mute_ctl_n)
    );

    a_r5_low_only_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_ctl_n |-> (gain == '0 || $past(fault)));

endmodule

// File: tb/tb_smr_softmute.sv
`timescale 1ns/1ps
module tb_smr_softmute;

    localparam int BASE  = 1152;
    localparam int FULL  = 4 * BASE;
    localparam int LVL_W = $clog2(FULL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mute_req_n = 1'b1;
    logic [1:0]       speed = 2'b00;
    logic             frame_tick = 1'b0;
    logic             pwr_down = 1'b0;
    logic             ratio_err = 1'b0;
    logic [LVL_W-1:0] gain;
    logic             mute_ctl_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    smr_softmute #(.BASE_FRAMES(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .mute_req_n(mute_req_n), .speed(speed),
        .frame_tick(frame_tick), .pwr_down(pwr_down), .ratio_err(ratio_err),
        .gain(gain), .mute_ctl_n(mute_ctl_n)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: gain level, latched step and mute line.
    int  m_lvl = 0;
    int  m_step = 4;
    bit  m_mute_n = 0;
    bit  m_valid = 0;

    function automatic int mode_step(input logic [1:0] s);
        if (s == 2'b00) return 4;
        if (s == 2'b01) return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        int  stp;
        int  nl;
        bit  flt;
        bit  up;
        m_valid <= 1'b1;
        if (!rst_n) begin
            m_lvl <= 0; m_step <= 4; m_mute_n <= 1'b0;
        end else begin
            flt = pwr_down || ratio_err;
            up  = mute_req_n && !flt;
            stp = (m_lvl == 0 || m_lvl == FULL) ? mode_step(speed) : m_step;
            nl  = m_lvl;
            if (frame_tick) begin
                if (up)  nl = (m_lvl + stp > FULL) ? FULL : m_lvl + stp;
                else     nl = (m_lvl - stp < 0) ? 0 : m_lvl - stp;
            end
            m_lvl    <= nl;
            m_step   <= stp;
            m_mute_n <= !flt && (up || nl != 0);
        end
    end

    // Cycle-by-cycle comparison against the reference (R2, R3, R5, R6).
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check(int'(gain) == m_lvl, "R2/R3 gain vs model", int'(gain), m_lvl);
            check(mute_ctl_n == m_mute_n, "R5/R6 mute vs model", int'(mute_ctl_n), int'(m_mute_n));
        end
    end

    // Drive n consecutive strobes, one per cycle.
    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) frame_tick = 1'b1;
        end
        @(negedge clk) frame_tick = 1'b0;
    endtask

    // Strobe every cycle until gain hits target; return strobe count.
    task automatic ramp_count(input int target, output int n, input bit check_mute);
        n = 0;
        @(negedge clk) frame_tick = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (check_mute && gain != 0)
                check(mute_ctl_n == 1'b1, "R5 mute high mid-ramp", int'(mute_ctl_n), 1);
        end while (int'(gain) != target && n < 20000);
        frame_tick = 1'b0;
    endtask

    initial begin
        int n;
        int g0;
        repeat (3) @(negedge clk);
        check(gain == 0, "R1 gain in reset", int'(gain), 0);
        check(mute_ctl_n == 1'b0, "R1 mute in reset", int'(mute_ctl_n), 0);
        rst_n = 1'b1;
        mute_req_n = 1'b0;
        @(negedge clk);
        check(gain == 0, "R1 gain after reset", int'(gain), 0);
        check(mute_ctl_n == 1'b0, "R1 mute after reset", int'(mute_ctl_n), 0);

        // R6: release at zero gain
        mute_req_n = 1'b1;
        @(negedge clk);
        check(mute_ctl_n == 1'b1, "R6 release at zero gain", int'(mute_ctl_n), 1);
        check(gain == 0, "R6 gain still zero", int'(gain), 0);

        // R2 single speed up
        ramp_count(FULL, n, 1'b0);
        check(n == 1152, "R2 single up strobes", n, 1152);

        // R4: no strobe, no change
        mute_req_n = 1'b0;
        repeat (6) @(negedge clk);
        check(gain == FULL, "R4 hold without strobe", int'(gain), FULL);

        // R3 + R5 single down
        ramp_count(0, n, 1'b1);
        check(n == 1152, "R3 single down strobes", n, 1152);
        check(mute_ctl_n == 1'b0, "R5 mute low at zero", int'(mute_ctl_n), 0);

        // R2 double speed
        speed = 2'b01; mute_req_n = 1'b1;
        ramp_count(FULL, n, 1'b0);
        check(n == 2304, "R2 double up strobes", n, 2304);
        mute_req_n = 1'b0;
        ramp_count(0, n, 1'b1);
        check(n == 2304, "R3 double down strobes", n, 2304);

        // R2 quad speed, code 10
        speed = 2'b10; mute_req_n = 1'b1;
        ramp_count(FULL, n, 1'b0);
        check(n == 4608, "R2 quad up strobes", n, 4608);

        // R7 reversal in single speed
        speed = 2'b00; mute_req_n = 1'b0;
        strobes(100);
        check(gain == FULL - 400, "R7 partial down", int'(gain), FULL - 400);
        mute_req_n = 1'b1;
        strobes(50);
        check(gain == FULL - 200, "R7 reversed up", int'(gain), FULL - 200);
        ramp_count(FULL, n, 1'b0);
        check(n == 50, "R7 finish from midpoint", n, 50);

        // R8 mode change mid-ramp: start quad, switch to single
        speed = 2'b10; mute_req_n = 1'b0;
        strobes(10);
        check(gain == FULL - 10, "R8 quad step at start", int'(gain), FULL - 10);
        speed = 2'b00;
        strobes(10);
        check(gain == FULL - 20, "R8 step held after mode change", int'(gain), FULL - 20);
        ramp_count(0, n, 1'b1);
        check(n == FULL - 20, "R8 quad count to zero", n, FULL - 20);

        // R2 code 11 behaves as quad
        speed = 2'b11; mute_req_n = 1'b1;
        strobes(1);
        check(gain == 1, "R2 code 11 step", int'(gain), 1);
        ramp_count(FULL, n, 1'b0);
        check(n == 4607, "R2 code 11 remaining", n, 4607);

        // R9 ratio fault: mute next cycle, gain falls, never rises
        speed = 2'b00;
        @(negedge clk) ratio_err = 1'b1;
        @(negedge clk);
        check(mute_ctl_n == 1'b0, "R9 ratio fault mutes", int'(mute_ctl_n), 0);
        g0 = int'(gain);
        strobes(20);
        check(int'(gain) == g0 - 80, "R9 gain falls under fault", int'(gain), g0 - 80);
        ratio_err = 1'b0;
        @(negedge clk);
        check(mute_ctl_n == 1'b1, "R6 release after fault", int'(mute_ctl_n), 1);
        ramp_count(FULL, n, 1'b0);

        // R9 power-down
        pwr_down = 1'b1;
        @(negedge clk);
        check(mute_ctl_n == 1'b0, "R9 power-down mutes", int'(mute_ctl_n), 0);
        ramp_count(0, n, 1'b0);
        check(n == 1152, "R9 ramp to zero in power-down", n, 1152);
        strobes(5);
        check(gain == 0, "R10 no underflow at zero", int'(gain), 0);
        pwr_down = 1'b0;
        ramp_count(FULL, n, 1'b0);
        strobes(5);
        check(gain == FULL, "R10 no overflow at full", int'(gain), FULL);

        // R1 reset mid-ramp
        mute_req_n = 1'b0;
        strobes(30);
        rst_n = 1'b0;
        @(negedge clk);
        check(gain == 0, "R1 reset clears gain", int'(gain), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule